// File: doc/BRIEF.md
# Asymmetric Dual-Pipe Issue Slotter

This block sits at the end of an in-order integer decode stage. Each cycle it is offered two candidate instructions. The older one is in the first slot and the younger one is in the second. Each candidate carries a valid bit and a 3-bit class code. The block also receives one stall flag per execution pipe from neighbouring units. The two pipes are called E0 and E1, and they are not equivalent:
- Memory writes, locked loads, shifts and multimedia operations can only use E0.
- Control transfers can only use E1.
- Arithmetic, logic, compares, conditional moves and plain loads can use either pipe.
- A memory write and a load are never issued together.
- A multi-cycle class needs both pipes and always issues by itself.

For each slot, the slotter registers an issue grant and the pipe chosen for it. The decode stage uses these to advance its queue by zero, one or two entries. Dependency checks, operand fetch and the execution units are handled elsewhere.

Top module: `issue_slotter`

## Requirements
- R1: While `rst` is high, and on the first clock edge that samples it high, every output is 0.
- R2: The outputs are registered. The outputs present after a rising edge reflect the inputs sampled at that edge.
- R3: Class 2 (locked load), 3 (store or barrier) and 5 (shift, multimedia or misc) are routed only to E0. A pipe field value of 0 means E0.
- R4: Class 4 (branch, jump or privileged call) is routed only to E1. A pipe field value of 1 means E1.
- R5: Class 0 (integer ALU or conditional move) and class 1 (plain load) may be routed to either pipe.
- R6: A store (class 3) is never granted in the same cycle as a load (class 1 or 2). In that case only the older instruction may issue.
- R7: Class 6 (multi-cycle) and class 7 (reserved, handled like class 6) issue only when both pipes are free. Their pipe field is reported as E0. Nothing issues beside them, and such a class in the younger slot never issues.
- R8: Issue is in order. The younger candidate is granted only if the older one is granted in the same cycle.
- R9: A pipe whose stall flag is high is not chosen for either slot in that cycle.
- R10: An older candidate that may use either pipe takes E0. The exceptions are when E0 is stalled, or when the younger candidate is pairable, may use only E0, and E1 is free. In those cases the older candidate takes E1.
- R11: When two instructions are granted, they use different pipes. The pipe field of a slot without a grant is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| old_vld | input | 1 | Older candidate present |
| old_cls | input | CLS_W (3) | Older candidate class code |
| yng_vld | input | 1 | Younger candidate present |
| yng_cls | input | CLS_W (3) | Younger candidate class code |
| e0_blk | input | 1 | E0 unavailable this cycle |
| e1_blk | input | 1 | E1 unavailable this cycle |
| old_go | output | 1 | Older candidate granted |
| old_pipe | output | 1 | Pipe for older candidate (0 = E0, 1 = E1) |
| yng_go | output | 1 | Younger candidate granted |
| yng_pipe | output | 1 | Pipe for younger candidate (0 = E0, 1 = E1) |

## Verification
The only state is the output register, so a wrong decision shows up one cycle after the candidates are offered. A wrong class-to-pipe mapping appears as a wrong pipe field or a missing grant on that same following cycle. A bad pairing rule appears as a younger grant where none is allowed, or as two grants on one pipe. The bench walks through every class combination together with every stall pattern. It compares each registered output against a behavioural model on every clock, so an error surfaces at the first cycle that exercises the faulty case.

// File: rtl/slot_pkg.sv
package slot_pkg;
  localparam int CLS_W = 3;
  localparam int NPIPE = 2;

  typedef enum logic [CLS_W-1:0] {
    CL_ALU = 3'd0, CL_LOAD = 3'd1, CL_LLOCK = 3'd2, CL_STORE = 3'd3,
    CL_BRANCH = 3'd4, CL_E0OP = 3'd5, CL_SOLO = 3'd6, CL_RSVD = 3'd7
  } cls_t;

  typedef struct packed {
    logic [NPIPE-1:0] mask;  // bit0 = E0, bit1 = E1; zero when slot empty
    logic ld;
    logic st;
    logic solo;
  } slot_info_t;
endpackage

// File: rtl/slot_decode.sv
module slot_decode
  import slot_pkg::*;
(
  input  logic             vld,
  input  logic [CLS_W-1:0] cls,
  output slot_info_t       info
);
  always_comb begin
    info = '0;
    if (vld) begin
      unique case (cls_t'(cls))
        CL_ALU, CL_LOAD:          info.mask = 2'b11;
        CL_LLOCK, CL_STORE,
        CL_E0OP:                  info.mask = 2'b01;
        CL_BRANCH:                info.mask = 2'b10;
        default:                  info.mask = 2'b11;
      endcase
      info.ld   = (cls_t'(cls) == CL_LOAD) || (cls_t'(cls) == CL_LLOCK);
      info.st   = (cls_t'(cls) == CL_STORE);
      info.solo = (cls_t'(cls) == CL_SOLO) || (cls_t'(cls) == CL_RSVD);
    end
  end
endmodule

// File: rtl/pair_picker.sv
module pair_picker
  import slot_pkg::*;
(
  input  slot_info_t       o_inf,
  input  slot_info_t       y_inf,
  input  logic [NPIPE-1:0] blk,
  output logic             g_o,
  output logic             p_o,
  output logic             g_y,
  output logic             p_y
);
  logic [NPIPE-1:0] avail, left, y_cand;
  logic pair_ok, y_e0only, o_ok, o_pipe;

  always_comb begin
    avail    = ~blk;
    pair_ok  = (y_inf.mask != '0) && !o_inf.solo && !y_inf.solo &&
               !((o_inf.ld && y_inf.st) || (o_inf.st && y_inf.ld));
    y_e0only = (y_inf.mask == 2'b01);
    if (o_inf.solo) o_ok = (avail == 2'b11);
    else            o_ok = |(o_inf.mask & avail);
    if (o_inf.solo || o_inf.mask == 2'b01)      o_pipe = 1'b0;
    else if (o_inf.mask == 2'b10)               o_pipe = 1'b1;
    else o_pipe = !avail[0] || (pair_ok && y_e0only && avail[1]);
    left   = avail & (o_pipe ? 2'b01 : 2'b10);
    y_cand = y_inf.mask & left;
    g_o = o_ok;
    p_o = o_ok && o_pipe;
    g_y = o_ok && pair_ok && (y_cand != '0);
    p_y = g_y && !y_cand[0];
  end
endmodule

// File: rtl/issue_slotter.sv
module issue_slotter
  import slot_pkg::*;
#(
  parameter int CW = CLS_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          old_vld,
  input  logic [CW-1:0] old_cls,
  input  logic          yng_vld,
  input  logic [CW-1:0] yng_cls,
  input  logic          e0_blk,
  input  logic          e1_blk,
  output logic          old_go,
  output logic          old_pipe,
  output logic          yng_go,
  output logic          yng_pipe
);
  localparam int NSLOT = 2;

  logic [NSLOT-1:0]   vld_a;
  logic [CW-1:0]      cls_a [NSLOT];
  slot_info_t         inf_a [NSLOT];
  logic g_o, p_o, g_y, p_y;

  assign vld_a    = {yng_vld, old_vld};
  assign cls_a[0] = old_cls;
  assign cls_a[1] = yng_cls;

  for (genvar s = 0; s < NSLOT; s++) begin : g_dec
    slot_decode u_dec (.vld(vld_a[s]), .cls(cls_a[s]), .info(inf_a[s]));
  end

  pair_picker u_pick (
    .o_inf(inf_a[0]), .y_inf(inf_a[1]), .blk({e1_blk, e0_blk}),
    .g_o(g_o), .p_o(p_o), .g_y(g_y), .p_y(p_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      old_go <= 1'b0; old_pipe <= 1'b0; yng_go <= 1'b0; yng_pipe <= 1'b0;
    end else begin
      old_go <= g_o; old_pipe <= p_o; yng_go <= g_y; yng_pipe <= p_y;
    end
  end
endmodule

// File: rtl/slot_chk.sv
module slot_chk (
  input logic       clk,
  input logic       rst,
  input logic       old_vld,
  input logic [2:0] old_cls,
  input logic       yng_vld,
  input logic [2:0] yng_cls,
  input logic       e0_blk,
  input logic       e1_blk,
  input logic       old_go,
  input logic       old_pipe,
  input logic       yng_go,
  input logic       yng_pipe
);
  assert_e0_only_R3: assert property (@(posedge clk) disable iff (rst)
    old_go && ($past(old_cls) inside {3'd2, 3'd3, 3'd5}) |-> !old_pipe);
  assert_e1_only_R4: assert property (@(posedge clk) disable iff (rst)
    yng_go && ($past(yng_cls) == 3'd4) |-> yng_pipe);
  assert_no_ldst_pair_R6: assert property (@(posedge clk) disable iff (rst)
    yng_go |-> !(($past(old_cls) == 3'd3) && ($past(yng_cls) inside {3'd1, 3'd2})) &&
               !(($past(yng_cls) == 3'd3) && ($past(old_cls) inside {3'd1, 3'd2})));
  assert_solo_alone_R7: assert property (@(posedge clk) disable iff (rst)
    old_go && ($past(old_cls) inside {3'd6, 3'd7}) |-> !yng_go);
  assert_in_order_R8: assert property (@(posedge clk) disable iff (rst)
    yng_go |-> old_go);
  assert_no_blocked_R9: assert property (@(posedge clk) disable iff (rst)
    old_go |-> !(old_pipe ? $past(e1_blk) : $past(e0_blk)));
  assert_distinct_R11: assert property (@(posedge clk) disable iff (rst)
    yng_go |-> (old_pipe != yng_pipe));
endmodule

bind issue_slotter slot_chk u_slot_chk (
  .clk(clk), .rst(rst), .old_vld(old_vld), .old_cls(old_cls),
  .yng_vld(yng_vld), .yng_cls(yng_cls), .e0_blk(e0_blk), .e1_blk(e1_blk),
  .old_go(old_go), .old_pipe(old_pipe), .yng_go(yng_go), .yng_pipe(yng_pipe)
);

// File: tb/tb_issue_slotter.sv
`timescale 1ns/1ps
module tb_issue_slotter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ov = 0, yv = 0, b0 = 0, b1 = 0;
  logic [2:0] oc = 0, yc = 0;
  logic og, op, yg, yp;
  int checks = 0, errors = 0;
  logic [3:0] exp_q = 4'b0;   // {og, op, yg, yp}
  string exp_tag = "R1";

  always #10 clk = ~clk;

  issue_slotter dut (
    .clk(clk), .rst(rst), .old_vld(ov), .old_cls(oc), .yng_vld(yv), .yng_cls(yc),
    .e0_blk(b0), .e1_blk(b1), .old_go(og), .old_pipe(op), .yng_go(yg), .yng_pipe(yp)
  );

  function automatic bit can_use(int c, int p);
    if (c == 2 || c == 3 || c == 5) return p == 0;
    if (c == 4) return p == 1;
    return 1;
  endfunction

  function automatic logic [3:0] model(bit v0, int c0, bit v1, int c1, bit k0, bit k1);
    bit free[2];
    bit solo0, solo1, ld0, ld1, pairable, yonly0;
    int po, py;
    free[0] = !k0; free[1] = !k1;
    if (!v0) return 4'b0;
    solo0 = (c0 >= 6); solo1 = (c1 >= 6);
    ld0 = (c0 == 1 || c0 == 2); ld1 = (c1 == 1 || c1 == 2);
    pairable = v1 && !solo0 && !solo1 && !(ld0 && c1 == 3) && !(c0 == 3 && ld1);
    yonly0 = can_use(c1, 0) && !can_use(c1, 1);
    if (solo0) begin
      if (free[0] && free[1]) return 4'b1000;
      return 4'b0;
    end
    po = -1;
    if (can_use(c0, 0) && can_use(c0, 1)) begin
      if (!free[0] || (pairable && yonly0 && free[1])) po = free[1] ? 1 : -1;
      else po = 0;
    end else if (can_use(c0, 0) && free[0]) po = 0;
    else if (can_use(c0, 1) && free[1]) po = 1;
    if (po < 0) return 4'b0;
    py = -1;
    if (pairable) begin
      for (int p = 0; p < 2; p++)
        if (py < 0 && p != po && free[p] && can_use(c1, p)) py = p;
    end
    return {1'b1, po == 1, py >= 0, py == 1};
  endfunction

  task automatic compare();
    checks++;
    if ({og, op, yg, yp} !== exp_q) begin
      errors++;
      $display("FAIL %s: got go/pipe %b expected %b (t=%0t)", exp_tag, {og, op, yg, yp}, exp_q, $time);
    end
  endtask

  task automatic step(bit v0, int c0, bit v1, int c1, bit k0, bit k1, string tag);
    @(negedge clk);
    compare();
    ov = v0; oc = 3'(c0); yv = v1; yc = 3'(c1); b0 = k0; b1 = k1;
    exp_q = model(v0, c0, v1, c1, k0, k1);
    exp_tag = tag;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ov = 1; oc = 3'd0; yv = 1; yc = 3'd0;   // R1: stimulus ignored in reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_tag = "R1"; exp_q = 4'b0; compare();
    rst = 1'b0; ov = 0; yv = 0;
    // Directed cases
    step(1, 3, 0, 0, 0, 0, "R3 store to E0");
    step(1, 2, 1, 0, 0, 0, "R3 locked load E0 + alu E1");
    step(1, 5, 1, 5, 0, 0, "R3 two E0-only, younger held");
    step(1, 4, 1, 4, 0, 0, "R4 two branches, younger held");
    step(1, 4, 1, 0, 0, 0, "R4 branch E1, alu E0");
    step(1, 0, 1, 0, 0, 0, "R5 alu pair");
    step(1, 1, 1, 1, 0, 0, "R5 two loads pair");
    step(1, 3, 1, 1, 0, 0, "R6 store then load");
    step(1, 2, 1, 3, 0, 0, "R6 locked load then store");
    step(1, 6, 1, 0, 0, 0, "R7 solo older");
    step(1, 6, 0, 0, 1, 0, "R7 solo with E0 stalled");
    step(1, 0, 1, 7, 0, 0, "R7 reserved younger held");
    step(0, 0, 1, 0, 0, 0, "R8 younger without older");
    step(1, 4, 1, 0, 0, 1, "R8 older blocked holds younger");
    step(1, 0, 1, 0, 1, 0, "R9 E0 stalled");
    step(1, 0, 1, 0, 1, 1, "R9 both stalled");
    step(1, 0, 1, 3, 0, 0, "R10 older yields E0 to store");
    step(1, 0, 1, 5, 0, 1, "R10 E1 stalled keeps older on E0");
    step(1, 1, 1, 4, 0, 0, "R11 pipes differ");
    step(0, 0, 0, 0, 0, 0, "R11 idle pipes zero");
    // Exhaustive sweep over classes and stalls
    for (int c0 = 0; c0 < 8; c0++)
      for (int c1 = 0; c1 < 8; c1++)
        for (int k = 0; k < 4; k++)
          step(1, c0, 1, c1, k[0], k[1], "R5 sweep");
    for (int i = 0; i < 400; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      step(r[0], int'(r[3:1]), r[4], int'(r[7:5]), r[8], r[9], "R2 random");
    end
    step(0, 0, 0, 0, 0, 0, "R2 drain");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule